// File: doc/BRIEF.md
# Timer Software Event Generator

This block is a 16-bit up-counting timer with one capture/compare channel and a repetition counter. Its centre is a write-only event register through which software fires update, channel capture/compare, commutation and break events. Each event acts in the same clock edge as the bus write. The bits of that register clear themselves, so a read always returns zero. The block keeps four status flags: update, channel 1, channel 1 overcapture and break. It also owns the main output enable bit, which a break event drops.

Software reaches every register through a simple synchronous bus. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The byte offsets are: control 0x00, interrupt enable 0x04, status 0x08, channel preload 0x0C, channel active 0x10 (read-only), event 0x14, period 0x18, repetition reload 0x1C, channel capture/compare value 0x20, counter 0x24 and output enable 0x28. Unmapped offsets read 0 and ignore writes.

A pulse on `trig_in` restarts the counter in the same way as the software update event. `ch1_is_input` selects whether the channel captures or compares.

Top module: `tmr_evgen_top`

## Requirements
- R1: After reset every register reads 0, and `irq_upd`, `irq_cc1`, `irq_brk` and `main_oe` are low.
- R2: With control bit 0 set, the counter steps by one each clock from 0 up to the period and then wraps to 0. On a wrap the repetition count is checked. If it is non-zero it decrements and no flag is set. If it is zero it reloads from 0x1C and sets status bit 0, provided control bit 1 (update disable) is 0.
- R3: While control bit 1 is 1, counter wraps never set status bit 0.
- R4: Writing 1 to event bit 0 does three things. It forces the counter to 0 and reloads the repetition count. It sets status bit 0 only when control bit 2 (update source restriction) and control bit 1 are both 0.
- R5: A one-cycle pulse on `trig_in` has the same effect on the counter, the repetition count and status bit 0 as event bit 0.
- R6: The event register at 0x14 reads 0. Writing 0 to any of its bits has no effect, and so does writing its reserved bits 15:8, 6 and 4:2.
- R7: Writing 1 to event bit 7 clears the output enable (0x28 bit 0, port `main_oe`) and sets status bit 7.
- R8: With `ch1_is_input` low, writing 1 to event bit 1 sets status bit 1 and leaves the value at 0x20 unchanged.
- R9: With `ch1_is_input` high, writing 1 to event bit 1 copies the counter into 0x20 and sets status bit 1. It also sets status bit 9 (overcapture) if status bit 1 was already 1.
- R10: The channel control field is mode bits 2:0, enable bit 3 and complementary enable bit 4. While control bit 3 (preload) is 1, writes to 0x0C leave 0x10 alone, and writing 1 to event bit 5 copies 0x0C into 0x10. While control bit 3 is 0, each write to 0x0C reaches 0x10 directly.
- R11: Writing the status register clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A hardware set in the same cycle as a clear leaves the flag at 1.
- R12: `irq_upd`, `irq_cc1` and `irq_brk` equal status bits 0, 1 and 7 ANDed with interrupt-enable bits 0, 1 and 7 at 0x04.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Combinational read data |
| trig_in | input | 1 | External restart pulse |
| ch1_is_input | input | 1 | Channel 1 mode: 1 capture, 0 compare |
| cnt_val | output | CNT_W | Current counter value |
| main_oe | output | 1 | Main output enable |
| irq_upd | output | 1 | Update interrupt request |
| irq_cc1 | output | 1 | Channel 1 interrupt request |
| irq_brk | output | 1 | Break interrupt request |

## Verification
The bench goes after the gating of the update flag by the two control bits. A design that mixed them up would flag a software restart that the source restriction should hide, or would miss a wrap.

It counts wrap cycles exactly, so a repetition counter that is off by one sets the flag four cycles early or late. It fires capture twice in input mode: a missing overcapture check, or a capture in compare mode, shows up at 0x20 or in status bit 9.

It also drives a status clear and a trigger in the same cycle, which catches a clear that beats the set. Reserved event bits and commutation without preload are shown to leave the counter, the flags and the active channel field alone.

// File: rtl/tmr_evgen_pkg.sv
package tmr_evgen_pkg;

   localparam int unsigned ADDR_W = 8;

   // register byte offsets
   localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_CHPRE = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_CHACT = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_EVGEN = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_PER   = 8'h18;
   localparam logic [ADDR_W-1:0] OFS_REP   = 8'h1C;
   localparam logic [ADDR_W-1:0] OFS_CCR1  = 8'h20;
   localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h24;
   localparam logic [ADDR_W-1:0] OFS_OE    = 8'h28;

   // event register bit positions
   localparam int EG_UPD = 0;
   localparam int EG_CC1 = 1;
   localparam int EG_COM = 5;
   localparam int EG_BRK = 7;

   // status / interrupt-enable bit positions
   localparam int ST_UPD = 0;
   localparam int ST_CC1 = 1;
   localparam int ST_BRK = 7;
   localparam int ST_OVC = 9;

   // internal flag vector indices
   localparam int NFLAG  = 4;
   localparam int FL_UPD = 0;
   localparam int FL_CC1 = 1;
   localparam int FL_OVC = 2;
   localparam int FL_BRK = 3;

   typedef struct packed {
      logic prel;   // bit 3: channel control preload
      logic urs;    // bit 2: update flag source restriction
      logic udis;   // bit 1: update disable
      logic en;     // bit 0: counter enable
   } ctrl_t;

   typedef struct packed {
      logic bie;
      logic ccie;
      logic uie;
   } ien_t;

   typedef struct packed {
      logic       nen;   // bit 4
      logic       en;    // bit 3
      logic [2:0] mode;  // bits 2:0
   } chctl_t;

endpackage

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned REP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cen,
   input  logic             udis,
   input  logic             urs,
   input  logic [CNT_W-1:0] period,
   input  logic [REP_W-1:0] rep_load,
   input  logic             sw_reinit,
   input  logic             trig_reinit,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             upd_set
);

   logic [CNT_W-1:0] cnt_q;
   logic [REP_W-1:0] rep_q;
   logic             reinit;
   logic             at_top;
   logic             wrap;
   logic             rep_zero;

   assign reinit   = sw_reinit | trig_reinit;
   assign at_top   = (cnt_q == period);
   assign wrap     = cen & at_top & ~reinit & ~cnt_wr;
   assign rep_zero = (rep_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rep_q <= '0;
      end else if (reinit) begin
         cnt_q <= '0;
         rep_q <= rep_load;
      end else if (cnt_wr) begin
         cnt_q <= cnt_wdata;
      end else if (cen) begin
         if (at_top) begin
            cnt_q <= '0;
            rep_q <= rep_zero ? rep_load : rep_q - 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign upd_set = ~udis & ((reinit & ~urs) | (wrap & rep_zero));
   assign cnt     = cnt_q;

   // R4
   reinit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> (cnt_q == '0));

   // R2
   rep_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && rep_zero) |=> (rep_q == $past(rep_load)));

   // R2
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_ch1.sv
module tmr_ch1
   import tmr_evgen_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter bit          HAS_COMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_input,
   input  logic             cc_gen,
   input  logic             com_gen,
   input  logic             preload_ctl,
   input  logic [CNT_W-1:0] cnt,
   input  logic             ccr_wr,
   input  logic [CNT_W-1:0] ccr_wdata,
   input  logic             pre_wr,
   input  chctl_t           pre_wdata,
   input  logic             cc_flag,
   output logic [CNT_W-1:0] ccr,
   output chctl_t           pre,
   output chctl_t           act,
   output logic             cc_set,
   output logic             ovc_set
);

   logic [CNT_W-1:0] ccr_q;
   chctl_t           pre_q;
   logic             capture;

   assign capture = cc_gen & is_input;
   assign cc_set  = cc_gen;
   assign ovc_set = capture & cc_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccr_q <= '0;
         pre_q <= '0;
      end else begin
         if (capture)     ccr_q <= cnt;
         else if (ccr_wr) ccr_q <= ccr_wdata;
         if (pre_wr)      pre_q <= pre_wdata;
      end
   end

   assign ccr = ccr_q;
   assign pre = pre_q;

   generate
      if (HAS_COMP) begin : g_shadow
         chctl_t act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      act_q <= '0;
            else if (com_gen && preload_ctl) act_q <= pre_q;
            else if (pre_wr && !preload_ctl) act_q <= pre_wdata;
         end
         assign act = act_q;

         // R10
         com_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (com_gen && preload_ctl) |=> (act_q == $past(pre_q)));

         // R10
         prel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_wr && preload_ctl) |=> $stable(act_q));
      end else begin : g_direct
         assign act = pre_q;
      end
   endgenerate

   // R9
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (ccr_q == $past(cnt)));

   // R8
   compare_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_gen && !is_input && !ccr_wr) |=> $stable(ccr_q));

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
   parameter int unsigned NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_i,
   input  logic          clr_wr,
   input  logic [NF-1:0] keep_i,
   output logic [NF-1:0] flag_o
);

   logic [NF-1:0] flag_q;
   logic [NF-1:0] flag_d;

   for (genvar i = 0; i < NF; i++) begin : g_bit
      assign flag_d[i] = set_i[i] | (flag_q[i] & ~(clr_wr & ~keep_i[i]));

      // R11
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_q[i]);

      // R11
      clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag_q[i]) |-> $past(clr_wr && !keep_i[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/tmr_evgen_top.sv
module tmr_evgen_top
   import tmr_evgen_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned REP_W    = 8,
   parameter bit          HAS_COMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              trig_in,
   input  logic              ch1_is_input,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              main_oe,
   output logic              irq_upd,
   output logic              irq_cc1,
   output logic              irq_brk
);

   localparam int unsigned CH_W = $bits(chctl_t);
   localparam int unsigned CT_W = $bits(ctrl_t);

   initial begin : param_chk
      assert (DATA_W >= 16) else $error("DATA_W must hold status bit 9");
      assert (CNT_W >= 2 && CNT_W <= DATA_W) else $error("CNT_W out of range");
      assert (REP_W >= 1 && REP_W <= DATA_W) else $error("REP_W out of range");
   end

   // address decode
   logic wr_ctrl, wr_ien, wr_stat, wr_chpre, wr_evgen, wr_per, wr_rep, wr_ccr, wr_cnt, wr_oe;
   assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
   assign wr_ien   = bus_wr && (bus_addr == OFS_IEN);
   assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
   assign wr_chpre = bus_wr && (bus_addr == OFS_CHPRE);
   assign wr_evgen = bus_wr && (bus_addr == OFS_EVGEN);
   assign wr_per   = bus_wr && (bus_addr == OFS_PER);
   assign wr_rep   = bus_wr && (bus_addr == OFS_REP);
   assign wr_ccr   = bus_wr && (bus_addr == OFS_CCR1);
   assign wr_cnt   = bus_wr && (bus_addr == OFS_CNT);
   assign wr_oe    = bus_wr && (bus_addr == OFS_OE);

   // self-clearing events: they exist only during the write cycle
   logic ev_ug, ev_cc1g, ev_comg, ev_bg;
   assign ev_ug   = wr_evgen & bus_wdata[EG_UPD];
   assign ev_cc1g = wr_evgen & bus_wdata[EG_CC1];
   assign ev_comg = wr_evgen & bus_wdata[EG_COM];
   assign ev_bg   = wr_evgen & bus_wdata[EG_BRK];

   ctrl_t            ctrl_q;
   ien_t             ien_q;
   logic [CNT_W-1:0] per_q;
   logic [REP_W-1:0] rld_q;
   logic             moe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= '0;
         per_q  <= '0;
         rld_q  <= '0;
         moe_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CT_W-1:0]);
         if (wr_ien)  ien_q  <= '{bie:  bus_wdata[ST_BRK],
                                  ccie: bus_wdata[ST_CC1],
                                  uie:  bus_wdata[ST_UPD]};
         if (wr_per)  per_q  <= bus_wdata[CNT_W-1:0];
         if (wr_rep)  rld_q  <= bus_wdata[REP_W-1:0];
         if (ev_bg)       moe_q <= 1'b0;
         else if (wr_oe)  moe_q <= bus_wdata[0];
      end
   end

   // counter and repetition counter
   logic [CNT_W-1:0] cnt;
   logic             upd_set;

   tmr_cnt_core #(.CNT_W(CNT_W), .REP_W(REP_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .cen         (ctrl_q.en),
      .udis        (ctrl_q.udis),
      .urs         (ctrl_q.urs),
      .period      (per_q),
      .rep_load    (rld_q),
      .sw_reinit   (ev_ug),
      .trig_reinit (trig_in),
      .cnt_wr      (wr_cnt),
      .cnt_wdata   (bus_wdata[CNT_W-1:0]),
      .cnt         (cnt),
      .upd_set     (upd_set)
   );

   // channel 1
   logic [NFLAG-1:0] flags;
   logic [CNT_W-1:0] ccr;
   chctl_t           ch_pre, ch_act;
   logic             cc_set, ovc_set;

   tmr_ch1 #(.CNT_W(CNT_W), .HAS_COMP(HAS_COMP)) u_ch1 (
      .clk         (clk),
      .rst_n       (rst_n),
      .is_input    (ch1_is_input),
      .cc_gen      (ev_cc1g),
      .com_gen     (ev_comg),
      .preload_ctl (ctrl_q.prel),
      .cnt         (cnt),
      .ccr_wr      (wr_ccr),
      .ccr_wdata   (bus_wdata[CNT_W-1:0]),
      .pre_wr      (wr_chpre),
      .pre_wdata   (chctl_t'(bus_wdata[CH_W-1:0])),
      .cc_flag     (flags[FL_CC1]),
      .ccr         (ccr),
      .pre         (ch_pre),
      .act         (ch_act),
      .cc_set      (cc_set),
      .ovc_set     (ovc_set)
   );

   // status flags
   logic [NFLAG-1:0] flag_set, flag_keep;

   always_comb begin
      flag_set          = '0;
      flag_set[FL_UPD]  = upd_set;
      flag_set[FL_CC1]  = cc_set;
      flag_set[FL_OVC]  = ovc_set;
      flag_set[FL_BRK]  = ev_bg;
      flag_keep         = '0;
      flag_keep[FL_UPD] = bus_wdata[ST_UPD];
      flag_keep[FL_CC1] = bus_wdata[ST_CC1];
      flag_keep[FL_OVC] = bus_wdata[ST_OVC];
      flag_keep[FL_BRK] = bus_wdata[ST_BRK];
   end

   tmr_flags #(.NF(NFLAG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set),
      .clr_wr (wr_stat),
      .keep_i (flag_keep),
      .flag_o (flags)
   );

   // read mux; the event register reads as zero
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL:  bus_rdata[CT_W-1:0] = ctrl_q;
         OFS_IEN: begin
            bus_rdata[ST_UPD] = ien_q.uie;
            bus_rdata[ST_CC1] = ien_q.ccie;
            bus_rdata[ST_BRK] = ien_q.bie;
         end
         OFS_STAT: begin
            bus_rdata[ST_UPD] = flags[FL_UPD];
            bus_rdata[ST_CC1] = flags[FL_CC1];
            bus_rdata[ST_BRK] = flags[FL_BRK];
            bus_rdata[ST_OVC] = flags[FL_OVC];
         end
         OFS_CHPRE: bus_rdata[CH_W-1:0]  = ch_pre;
         OFS_CHACT: bus_rdata[CH_W-1:0]  = ch_act;
         OFS_PER:   bus_rdata[CNT_W-1:0] = per_q;
         OFS_REP:   bus_rdata[REP_W-1:0] = rld_q;
         OFS_CCR1:  bus_rdata[CNT_W-1:0] = ccr;
         OFS_CNT:   bus_rdata[CNT_W-1:0] = cnt;
         OFS_OE:    bus_rdata[0]         = moe_q;
         default:   bus_rdata = '0;
      endcase
   end

   assign cnt_val = cnt;
   assign main_oe = moe_q;
   assign irq_upd = flags[FL_UPD] & ien_q.uie;
   assign irq_cc1 = flags[FL_CC1] & ien_q.ccie;
   assign irq_brk = flags[FL_BRK] & ien_q.bie;

   // R7
   brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bg |=> (!moe_q && flags[FL_BRK]));

   // R9
   ovc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_cc1g && ch1_is_input && flags[FL_CC1]) |=> flags[FL_OVC]);

endmodule

// File: tb/tb_tmr_evgen_top.sv
`timescale 1ns/1ps
module tb_tmr_evgen_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_rdata;
   logic        trig_in = 1'b0;
   logic        ch1_is_input = 1'b0;
   logic [15:0] cnt_val;
   logic        main_oe, irq_upd, irq_cc1, irq_brk;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tmr_evgen_top dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rdata(bus_rdata), .trig_in(trig_in),
      .ch1_is_input(ch1_is_input), .cnt_val(cnt_val), .main_oe(main_oe),
      .irq_upd(irq_upd), .irq_cc1(irq_cc1), .irq_brk(irq_brk)
   );

   // {req[4], wr_addr[8], wr_data[16], ch_in[1], rd_addr[8], expected[16]}
   localparam int NV = 41;
   localparam logic [52:0] VEC [NV] = '{
      {4'd2,  8'h18, 16'h0003, 1'b0, 8'h18, 16'h0003},  // R2 period
      {4'd4,  8'h24, 16'h0055, 1'b0, 8'h24, 16'h0055},  // R4 preset counter
      {4'd4,  8'h14, 16'h0001, 1'b0, 8'h24, 16'h0000},  // R4 restart clears counter
      {4'd6,  8'h14, 16'h0000, 1'b0, 8'h08, 16'h0001},  // R6 zero write, flag from R4
      {4'd11, 8'h08, 16'h0000, 1'b0, 8'h08, 16'h0000},  // R11 clear
      {4'd4,  8'h00, 16'h0004, 1'b0, 8'h00, 16'h0004},  // R4 source restriction on
      {4'd4,  8'h24, 16'h0022, 1'b0, 8'h24, 16'h0022},  // R4
      {4'd4,  8'h14, 16'h0001, 1'b0, 8'h24, 16'h0000},  // R4 still restarts
      {4'd4,  8'hFC, 16'h0000, 1'b0, 8'h08, 16'h0000},  // R4 no flag
      {4'd4,  8'h00, 16'h0002, 1'b0, 8'h00, 16'h0002},  // R4 update disable
      {4'd4,  8'h14, 16'h0001, 1'b0, 8'h08, 16'h0000},  // R4 no flag
      {4'd4,  8'h00, 16'h0000, 1'b0, 8'h00, 16'h0000},  // R4
      {4'd6,  8'h24, 16'h0033, 1'b0, 8'h24, 16'h0033},  // R6
      {4'd6,  8'h28, 16'h0001, 1'b0, 8'h28, 16'h0001},  // R6 output enable on
      {4'd6,  8'h14, 16'hFF5C, 1'b0, 8'h24, 16'h0033},  // R6 reserved bits
      {4'd6,  8'hFC, 16'h0000, 1'b0, 8'h08, 16'h0000},  // R6
      {4'd6,  8'hFC, 16'h0000, 1'b0, 8'h28, 16'h0001},  // R6
      {4'd6,  8'hFC, 16'h0000, 1'b0, 8'h14, 16'h0000},  // R6 reads zero
      {4'd7,  8'h14, 16'h0080, 1'b0, 8'h28, 16'h0000},  // R7 break
      {4'd7,  8'hFC, 16'h0000, 1'b0, 8'h08, 16'h0080},  // R7
      {4'd11, 8'h14, 16'h0001, 1'b0, 8'h08, 16'h0081},  // R11
      {4'd11, 8'h08, 16'h0001, 1'b0, 8'h08, 16'h0001},  // R11 keep 1 clear 0
      {4'd11, 8'h08, 16'h0000, 1'b0, 8'h08, 16'h0000},  // R11
      {4'd8,  8'h20, 16'h1234, 1'b0, 8'h20, 16'h1234},  // R8
      {4'd8,  8'h24, 16'h0077, 1'b0, 8'h24, 16'h0077},  // R8
      {4'd8,  8'h14, 16'h0002, 1'b0, 8'h20, 16'h1234},  // R8 compare: no capture
      {4'd8,  8'hFC, 16'h0000, 1'b0, 8'h08, 16'h0002},  // R8
      {4'd9,  8'h14, 16'h0002, 1'b1, 8'h20, 16'h0077},  // R9 capture
      {4'd9,  8'hFC, 16'h0000, 1'b1, 8'h08, 16'h0202},  // R9 overcapture
      {4'd9,  8'h08, 16'h0000, 1'b1, 8'h08, 16'h0000},  // R9
      {4'd9,  8'h24, 16'h0088, 1'b1, 8'h24, 16'h0088},  // R9
      {4'd9,  8'h14, 16'h0002, 1'b1, 8'h20, 16'h0088},  // R9
      {4'd9,  8'hFC, 16'h0000, 1'b1, 8'h08, 16'h0002},  // R9 no overcapture
      {4'd10, 8'h00, 16'h0008, 1'b0, 8'h00, 16'h0008},  // R10 preload on
      {4'd10, 8'h0C, 16'h0015, 1'b0, 8'h10, 16'h0000},  // R10 held
      {4'd10, 8'hFC, 16'h0000, 1'b0, 8'h0C, 16'h0015},  // R10
      {4'd10, 8'h14, 16'h0020, 1'b0, 8'h10, 16'h0015},  // R10 commutation
      {4'd10, 8'h00, 16'h0000, 1'b0, 8'h00, 16'h0000},  // R10 preload off
      {4'd10, 8'h0C, 16'h000A, 1'b0, 8'h10, 16'h000A},  // R10 direct
      {4'd10, 8'h14, 16'h0020, 1'b0, 8'h10, 16'h000A},  // R10
      {4'd11, 8'h08, 16'h0000, 1'b0, 8'h08, 16'h0000}   // R11
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic trig_pulse();
      @(negedge clk);
      trig_in = 1'b1;
      @(posedge clk);
      @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin : main
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      foreach (VEC[k]) begin end
      for (int a = 0; a <= 8'h28; a += 4) begin
         bus_read(a[7:0], rd);
         check($sformatf("R1 reg %h", a[7:0]), rd, 16'h0000);
      end
      check("R1 main_oe", {15'd0, main_oe}, 16'h0000);
      check("R1 irqs", {13'd0, irq_upd, irq_cc1, irq_brk}, 16'h0000);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [52:0] v;
         v = VEC[i];
         ch1_is_input = v[24];
         bus_write(v[48:41], v[40:25]);
         bus_read(v[23:16], rd);
         check($sformatf("R%0d vec %0d", v[52:49], i), rd, v[15:0]);
      end
      ch1_is_input = 1'b0;

      // R2 overflow with repetition count 1, period 3
      bus_write(8'h1C, 16'h0001);
      bus_write(8'h04, 16'h0001);
      bus_write(8'h14, 16'h0001);
      bus_write(8'h08, 16'h0000);
      bus_write(8'h00, 16'h0001);          // counting starts next edge
      repeat (7) @(posedge clk);
      @(negedge clk);
      bus_read(8'h08, rd);
      check("R2 first wrap no flag", rd, 16'h0000);
      @(negedge clk);
      bus_read(8'h08, rd);
      check("R2 second wrap flag", rd, 16'h0001);
      check("R12 irq_upd", {15'd0, irq_upd}, 16'h0001);

      // R3 update disable blocks wrap flag
      bus_write(8'h00, 16'h0002);
      bus_write(8'h08, 16'h0000);
      bus_write(8'h14, 16'h0001);
      bus_write(8'h00, 16'h0003);
      repeat (12) @(posedge clk);
      @(negedge clk);
      bus_read(8'h08, rd);
      check("R3 no flag while disabled", rd, 16'h0000);
      check("R3 irq_upd low", {15'd0, irq_upd}, 16'h0000);
      bus_write(8'h00, 16'h0000);

      // R5 external trigger
      bus_write(8'h24, 16'h0040);
      bus_write(8'h08, 16'h0000);
      trig_pulse();
      bus_read(8'h24, rd);
      check("R5 trigger clears counter", rd, 16'h0000);
      bus_read(8'h08, rd);
      check("R5 trigger flag", rd, 16'h0001);
      bus_write(8'h00, 16'h0004);
      bus_write(8'h08, 16'h0000);
      bus_write(8'h24, 16'h0040);
      trig_pulse();
      bus_read(8'h24, rd);
      check("R5 restricted clears counter", rd, 16'h0000);
      bus_read(8'h08, rd);
      check("R5 restricted no flag", rd, 16'h0000);
      bus_write(8'h00, 16'h0000);

      // R11 set beats clear in the same cycle
      @(negedge clk);
      bus_addr = 8'h08; bus_wdata = 16'h0000; bus_wr = 1'b1; trig_in = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; trig_in = 1'b0;
      bus_read(8'h08, rd);
      check("R11 set wins", rd, 16'h0001);

      // R12 interrupt gating
      bus_write(8'h08, 16'h0000);
      bus_write(8'h04, 16'h0082);
      bus_write(8'h14, 16'h0082);
      check("R12 irq lines", {13'd0, irq_upd, irq_cc1, irq_brk}, 16'h0003);
      check("R7 main_oe low", {15'd0, main_oe}, 16'h0000);
      bus_write(8'h04, 16'h0000);
      check("R12 irq masked", {13'd0, irq_upd, irq_cc1, irq_brk}, 16'h0000);
      bus_write(8'h28, 16'h0001);
      check("R7 main_oe set", {15'd0, main_oe}, 16'h0001);

      summary();
   end

endmodule